// File: doc/BRIEF.md
# Merging Store Write Buffer

This block sits between a pipeline that retires 8-byte stores and the write port of the next cache level, which takes 16 bytes at a time. Each entry holds one aligned 16-byte block, its data and a per-byte mask. A store is written into an entry that already holds its block, as long as that entry is not being offered on the write port. This lets two half-block stores leave as a single wide write instead of two.

Entries leave in the order they were allocated. Once an entry has been handed over, the port stays occupied for a fixed number of cycles. During that time the waiting entries keep collecting stores. When every entry holds data and the incoming store cannot join any of them, the store input stalls. Flags report when the buffer is full and when it is empty.

Top module: `wbm_store_buffer`

## Requirements
- R1: After reset the buffer shows empty=1 and full=0, it offers nothing on the write port, and it is ready for a store.
- R2: Store byte k is `st_data[8k+7:8k]`, enabled by `st_be[k]`. The address bits below bit 3 are ignored. Bit 3 selects the low half (0) or the high half (1) of the block, and bits above 3 form the block address. A new entry carries lane 8*half+k in `dr_data[8*lane+7:8*lane]` and `dr_mask[lane]`. Lanes that were not written have mask 0 and data 0. `dr_addr` has its low 4 bits at zero.
- R3: A store whose block matches an entry that holds data and is not being offered merges into that entry. Its enabled bytes overwrite the entry's bytes and set their mask bits. The entry's other bytes keep their value, and no entry is added.
- R4: An entry being offered on the write port takes no more merges. A store to its block allocates a new entry instead.
- R5: Entries leave on the write port in allocation order.
- R6: An entry at the head of the queue is offered in the cycle after it was written, if the port is free. While `dr_valid` is high and `dr_ready` is low, the address, data and mask hold steady.
- R7: After each accepted write, `dr_valid` stays low for DRAIN_CYCLES-1 cycles, so accepted writes are at least DRAIN_CYCLES cycles apart.
- R8: With every entry in use, a store that cannot merge sees `st_ready` low and is not taken, while a store that can merge is still accepted.
- R9: The full flag is high exactly when all DEPTH entries hold data, and the empty flag is high exactly when none does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store can be taken this cycle |
| st_addr | input | ADDR_W | Store byte address |
| st_data | input | 8*ST_BYTES | Store data |
| st_be | input | ST_BYTES | Store byte enables |
| dr_valid | output | 1 | Wide write offered to the next level |
| dr_ready | input | 1 | Next level takes the write |
| dr_addr | output | ADDR_W | Block-aligned write address |
| dr_data | output | 8*ST_BYTES*HALVES | Block data |
| dr_mask | output | ST_BYTES*HALVES | Byte mask of the block |
| buf_full | output | 1 | All entries in use |
| buf_empty | output | 1 | No entry in use |

## Verification
The bench builds the block with its default parameters: four entries, 8-byte stores, two halves per block and a four-cycle write occupancy. With four entries, the full condition is reached after four stores to distinct blocks. The stall, the merge while full, and the refused merge into the offered head can then be shown in one short scenario. The four-cycle occupancy leaves a window of three cycles in which the next head is not yet offered. Two stores landing inside that window show merging, partial byte enables and the byte overwrite.

// File: rtl/wbm_pkg.sv
package wbm_pkg;

   // Per-slot write command for one cycle
   typedef enum logic [1:0] {
      SLOT_KEEP  = 2'd0,
      SLOT_FILL  = 2'd1,
      SLOT_MERGE = 2'd2
   } slot_op_e;

   function automatic bit is_pow2(int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/wbm_slot.sv
module wbm_slot
   import wbm_pkg::*;
#(
   parameter int unsigned BLK_W    = 28,
   parameter int unsigned ST_BYTES = 8,
   parameter int unsigned HALVES   = 2,
   localparam int unsigned SEL_W      = $clog2(HALVES),
   localparam int unsigned LINE_BYTES = ST_BYTES * HALVES
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  slot_op_e                op,
   input  logic                    drop,
   input  logic [BLK_W-1:0]        in_blk,
   input  logic [SEL_W-1:0]        in_sel,
   input  logic [ST_BYTES*8-1:0]   in_data,
   input  logic [ST_BYTES-1:0]     in_be,
   output logic                    out_vld,
   output logic [BLK_W-1:0]        out_blk,
   output logic [LINE_BYTES*8-1:0] out_data,
   output logic [LINE_BYTES-1:0]   out_mask
);

   logic                    vld_q;
   logic [BLK_W-1:0]        blk_q;
   logic [LINE_BYTES*8-1:0] data_q;
   logic [LINE_BYTES-1:0]   mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         blk_q  <= '0;
         data_q <= '0;
         mask_q <= '0;
      end else begin
         if (drop) begin
            vld_q <= 1'b0;
         end
         case (op)
            SLOT_FILL: begin
               vld_q <= 1'b1;
               blk_q <= in_blk;
               for (int h = 0; h < int'(HALVES); h++) begin
                  for (int k = 0; k < int'(ST_BYTES); k++) begin
                     if ((SEL_W'(h) == in_sel) && in_be[k]) begin
                        data_q[(h*ST_BYTES+k)*8 +: 8] <= in_data[k*8 +: 8];
                        mask_q[h*ST_BYTES+k]          <= 1'b1;
                     end else begin
                        data_q[(h*ST_BYTES+k)*8 +: 8] <= 8'h00;
                        mask_q[h*ST_BYTES+k]          <= 1'b0;
                     end
                  end
               end
            end
            SLOT_MERGE: begin
               for (int h = 0; h < int'(HALVES); h++) begin
                  for (int k = 0; k < int'(ST_BYTES); k++) begin
                     if ((SEL_W'(h) == in_sel) && in_be[k]) begin
                        data_q[(h*ST_BYTES+k)*8 +: 8] <= in_data[k*8 +: 8];
                        mask_q[h*ST_BYTES+k]          <= 1'b1;
                     end
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign out_vld  = vld_q;
   assign out_blk  = blk_q;
   assign out_data = data_q;
   assign out_mask = mask_q;

endmodule

// File: rtl/wbm_match.sv
module wbm_match #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned BLK_W = 28,
   localparam int unsigned PTR_W = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0] vld,
   input  logic [DEPTH-1:0] busy,
   input  logic [BLK_W-1:0] blks [DEPTH],
   input  logic [BLK_W-1:0] probe,
   output logic [DEPTH-1:0] hit_vec,
   output logic             hit_any,
   output logic [PTR_W-1:0] hit_idx
);

   // One comparator per entry; an entry on offer is excluded
   for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      assign hit_vec[i] = vld[i] & ~busy[i] & (blks[i] == probe);
   end

   // Lowest index wins (at most one hit is expected)
   always_comb begin
      hit_idx = '0;
      for (int i = int'(DEPTH) - 1; i >= 0; i--) begin
         if (hit_vec[i]) begin
            hit_idx = PTR_W'(i);
         end
      end
   end

   assign hit_any = |hit_vec;

endmodule

// File: rtl/wbm_drain.sv
module wbm_drain
   import wbm_pkg::*;
#(
   parameter int unsigned DEPTH        = 4,
   parameter int unsigned DRAIN_CYCLES = 4,
   localparam int unsigned PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DEPTH-1:0] vld,
   input  logic             dr_ready,
   output logic             dr_valid,
   output logic             take,
   output logic [PTR_W-1:0] head,
   output logic [DEPTH-1:0] busy
);

   logic             port_free;
   logic [PTR_W-1:0] head_q;
   logic [PTR_W-1:0] head_inc;

   // Pointer wrap: free for power-of-two depth, compare otherwise
   if (is_pow2(DEPTH)) begin : g_wrap_pow2
      assign head_inc = head_q + 1'b1;
   end else begin : g_wrap_cmp
      assign head_inc = (head_q == PTR_W'(DEPTH - 1)) ? '0 : head_q + 1'b1;
   end

   // Port occupancy after each accepted write
   if (DRAIN_CYCLES > 1) begin : g_cool
      localparam int unsigned CW = $clog2(DRAIN_CYCLES);
      logic [CW-1:0] cool_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cool_q <= '0;
         end else if (take) begin
            cool_q <= CW'(DRAIN_CYCLES - 1);
         end else if (cool_q != '0) begin
            cool_q <= cool_q - 1'b1;
         end
      end
      assign port_free = (cool_q == '0);
   end else begin : g_nocool
      assign port_free = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
      end else if (take) begin
         head_q <= head_inc;
      end
   end

   assign head     = head_q;
   assign dr_valid = vld[head_q] & port_free;
   assign take     = dr_valid & dr_ready;
   assign busy     = dr_valid ? (DEPTH'(1) << head_q) : '0;

endmodule

// File: rtl/wbm_store_buffer.sv
module wbm_store_buffer
   import wbm_pkg::*;
#(
   parameter int unsigned ADDR_W       = 32,
   parameter int unsigned ST_BYTES     = 8,
   parameter int unsigned HALVES       = 2,
   parameter int unsigned DEPTH        = 4,
   parameter int unsigned DRAIN_CYCLES = 4,
   localparam int unsigned LINE_BYTES = ST_BYTES * HALVES,
   localparam int unsigned OFS_W      = $clog2(ST_BYTES),
   localparam int unsigned SEL_W      = $clog2(HALVES),
   localparam int unsigned BLK_LSB    = OFS_W + SEL_W,
   localparam int unsigned BLK_W      = ADDR_W - BLK_LSB,
   localparam int unsigned PTR_W      = $clog2(DEPTH),
   localparam int unsigned CNT_W      = $clog2(DEPTH + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    st_valid,
   output logic                    st_ready,
   input  logic [ADDR_W-1:0]       st_addr,
   input  logic [ST_BYTES*8-1:0]   st_data,
   input  logic [ST_BYTES-1:0]     st_be,
   output logic                    dr_valid,
   input  logic                    dr_ready,
   output logic [ADDR_W-1:0]       dr_addr,
   output logic [LINE_BYTES*8-1:0] dr_data,
   output logic [LINE_BYTES-1:0]   dr_mask,
   output logic                    buf_full,
   output logic                    buf_empty
);

   // Elaboration-time parameter checks
   if (DEPTH < 2) begin : g_bad_depth
      $error("wbm_store_buffer: DEPTH must be at least 2");
   end
   if (HALVES < 2 || !is_pow2(HALVES)) begin : g_bad_halves
      $error("wbm_store_buffer: HALVES must be a power of two, at least 2");
   end
   if (!is_pow2(ST_BYTES)) begin : g_bad_width
      $error("wbm_store_buffer: ST_BYTES must be a power of two");
   end
   if (DRAIN_CYCLES < 1) begin : g_bad_drain
      $error("wbm_store_buffer: DRAIN_CYCLES must be at least 1");
   end
   if (ADDR_W <= BLK_LSB) begin : g_bad_addr
      $error("wbm_store_buffer: ADDR_W too small for the block size");
   end

   // Address split
   logic [BLK_W-1:0] st_blk;
   logic [SEL_W-1:0] st_sel;
   logic             lsb_unused;

   assign st_blk     = st_addr[ADDR_W-1:BLK_LSB];
   assign st_sel     = st_addr[BLK_LSB-1:OFS_W];
   assign lsb_unused = ^st_addr[OFS_W-1:0];

   // Slot state
   logic                    vld_u     [DEPTH];
   logic [BLK_W-1:0]        slot_blk  [DEPTH];
   logic [LINE_BYTES*8-1:0] slot_data [DEPTH];
   logic [LINE_BYTES-1:0]   slot_mask [DEPTH];
   logic [DEPTH-1:0]        slot_vld;

   always_comb begin
      for (int i = 0; i < int'(DEPTH); i++) begin
         slot_vld[i] = vld_u[i];
      end
   end

   // Queue bookkeeping
   logic [PTR_W-1:0] tail;
   logic [CNT_W-1:0] count;
   logic [PTR_W-1:0] head;
   logic [DEPTH-1:0] busy;
   logic             take;

   // Merge search
   logic [DEPTH-1:0] hit_vec;
   logic             hit_any;
   logic [PTR_W-1:0] hit_idx;

   wbm_match #(
      .DEPTH (DEPTH),
      .BLK_W (BLK_W)
   ) u_match (
      .vld     (slot_vld),
      .busy    (busy),
      .blks    (slot_blk),
      .probe   (st_blk),
      .hit_vec (hit_vec),
      .hit_any (hit_any),
      .hit_idx (hit_idx)
   );

   // Drain sequencing
   wbm_drain #(
      .DEPTH        (DEPTH),
      .DRAIN_CYCLES (DRAIN_CYCLES)
   ) u_drain (
      .clk      (clk),
      .rst_n    (rst_n),
      .vld      (slot_vld),
      .dr_ready (dr_ready),
      .dr_valid (dr_valid),
      .take     (take),
      .head     (head),
      .busy     (busy)
   );

   // Store acceptance
   logic at_cap;
   logic accept;
   logic do_merge;
   logic do_alloc;

   assign at_cap   = (count == CNT_W'(DEPTH));
   assign st_ready = hit_any | ~at_cap;
   assign accept   = st_valid & st_ready;
   assign do_merge = accept & hit_any;
   assign do_alloc = accept & ~hit_any;

   // Entry array
   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      slot_op_e op_i;
      logic     drop_i;

      always_comb begin
         if (do_merge && (hit_idx == PTR_W'(i))) begin
            op_i = SLOT_MERGE;
         end else if (do_alloc && (tail == PTR_W'(i))) begin
            op_i = SLOT_FILL;
         end else begin
            op_i = SLOT_KEEP;
         end
      end

      assign drop_i = take & (head == PTR_W'(i));

      wbm_slot #(
         .BLK_W    (BLK_W),
         .ST_BYTES (ST_BYTES),
         .HALVES   (HALVES)
      ) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .op       (op_i),
         .drop     (drop_i),
         .in_blk   (st_blk),
         .in_sel   (st_sel),
         .in_data  (st_data),
         .in_be    (st_be),
         .out_vld  (vld_u[i]),
         .out_blk  (slot_blk[i]),
         .out_data (slot_data[i]),
         .out_mask (slot_mask[i])
      );
   end

   // Tail pointer and occupancy
   logic [PTR_W-1:0] tail_inc;

   if (is_pow2(DEPTH)) begin : g_tail_pow2
      assign tail_inc = tail + 1'b1;
   end else begin : g_tail_cmp
      assign tail_inc = (tail == PTR_W'(DEPTH - 1)) ? '0 : tail + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tail  <= '0;
         count <= '0;
      end else begin
         if (do_alloc) begin
            tail <= tail_inc;
         end
         count <= count + CNT_W'(do_alloc) - CNT_W'(take);
      end
   end

   // Write port view of the head entry
   assign dr_addr   = {slot_blk[head], {BLK_LSB{1'b0}}};
   assign dr_data   = slot_data[head];
   assign dr_mask   = slot_mask[head];
   assign buf_full  = at_cap;
   assign buf_empty = (count == '0);

endmodule

// File: rtl/wbm_checker.sv
module wbm_checker #(
   parameter int unsigned DEPTH        = 4,
   parameter int unsigned DRAIN_CYCLES = 4,
   parameter int unsigned ADDR_W       = 32,
   parameter int unsigned LINE_BYTES   = 16,
   parameter int unsigned CNT_W        = 3
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    st_valid,
   input logic                    st_ready,
   input logic                    dr_valid,
   input logic                    dr_ready,
   input logic [ADDR_W-1:0]       dr_addr,
   input logic [LINE_BYTES*8-1:0] dr_data,
   input logic [LINE_BYTES-1:0]   dr_mask,
   input logic                    buf_full,
   input logic                    buf_empty,
   input logic [DEPTH-1:0]        hit_vec,
   input logic [CNT_W-1:0]        count
);

   localparam int unsigned GW = $clog2(DRAIN_CYCLES + 1);

   // Cycles since the last accepted write, saturating
   logic [GW-1:0] since;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since <= GW'(DRAIN_CYCLES);
      end else if (dr_valid && dr_ready) begin
         since <= '0;
      end else if (since < GW'(DRAIN_CYCLES)) begin
         since <= since + 1'b1;
      end
   end

   // R6: an unaccepted offer holds steady
   assert_offer_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dr_valid && !dr_ready) |=> (dr_valid && $stable(dr_addr) && $stable(dr_data) && $stable(dr_mask)));

   // R7: spacing between accepted writes
   assert_port_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dr_valid |-> (since >= GW'(DRAIN_CYCLES - 1)));

   // R8: a stalled store only happens with every entry in use
   assert_stall_only_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && !st_ready) |-> buf_full);

   // R3: at most one mergeable entry per block
   assert_single_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   // R9: flags consistent with occupancy
   assert_flags_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(buf_full && buf_empty));

   assert_empty_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      buf_empty |-> !dr_valid);

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   // R5/R9: a write leaving with no store arriving lowers occupancy by one
   assert_drain_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dr_valid && dr_ready && !st_valid) |=> (count == $past(count) - 1'b1));

endmodule

bind wbm_store_buffer wbm_checker #(
   .DEPTH        (DEPTH),
   .DRAIN_CYCLES (DRAIN_CYCLES),
   .ADDR_W       (ADDR_W),
   .LINE_BYTES   (LINE_BYTES),
   .CNT_W        (CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .st_valid  (st_valid),
   .st_ready  (st_ready),
   .dr_valid  (dr_valid),
   .dr_ready  (dr_ready),
   .dr_addr   (dr_addr),
   .dr_data   (dr_data),
   .dr_mask   (dr_mask),
   .buf_full  (buf_full),
   .buf_empty (buf_empty),
   .hit_vec   (hit_vec),
   .count     (count)
);

// File: tb/sim_wbm_store_buffer.sv
module sim_wbm_store_buffer;

   localparam int PERIOD = 10;
   localparam int DC     = 4;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         st_valid;
   logic         st_ready;
   logic [31:0]  st_addr;
   logic [63:0]  st_data;
   logic [7:0]   st_be;
   logic         dr_valid;
   logic         dr_ready;
   logic [31:0]  dr_addr;
   logic [127:0] dr_data;
   logic [15:0]  dr_mask;
   logic         buf_full;
   logic         buf_empty;

   always #(PERIOD/2) clk = ~clk;

   wbm_store_buffer u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .st_valid  (st_valid),
      .st_ready  (st_ready),
      .st_addr   (st_addr),
      .st_data   (st_data),
      .st_be     (st_be),
      .dr_valid  (dr_valid),
      .dr_ready  (dr_ready),
      .dr_addr   (dr_addr),
      .dr_data   (dr_data),
      .dr_mask   (dr_mask),
      .buf_full  (buf_full),
      .buf_empty (buf_empty)
   );

   int total = 0;
   int bad   = 0;
   int cyc   = 0;

   // Capture of accepted writes and accepted stores
   logic [31:0]  c_addr [64];
   logic [127:0] c_data [64];
   logic [15:0]  c_mask [64];
   int           c_cyc  [64];
   int           ncap = 0;
   int           a_cyc  [64];
   int           nacc = 0;

   always @(posedge clk) begin
      if (rst_n === 1'b1) begin
         if (dr_valid && dr_ready && ncap < 64) begin
            c_addr[ncap] = dr_addr;
            c_data[ncap] = dr_data;
            c_mask[ncap] = dr_mask;
            c_cyc[ncap]  = cyc;
            ncap = ncap + 1;
         end
         if (st_valid && st_ready && nacc < 64) begin
            a_cyc[nacc] = cyc;
            nacc = nacc + 1;
         end
      end
      cyc = cyc + 1;
   end

   task automatic check(input string req, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   // Offer a store for one edge; report whether it was taken
   task automatic push(input logic [31:0] a, input logic [63:0] d,
                       input logic [7:0] be, output bit acc);
      @(negedge clk);
      st_valid = 1'b1;
      st_addr  = a;
      st_data  = d;
      st_be    = be;
      #(PERIOD/4);
      acc = st_ready;
      @(posedge clk);
   endtask

   task automatic idle();
      @(negedge clk);
      st_valid = 1'b0;
   endtask

   task automatic wait_caps(input int n);
      for (int i = 0; i < 100 && ncap < n; i++) @(negedge clk);
   endtask

   task automatic settle();
      repeat (DC + 2) @(negedge clk);
   endtask

   // R1
   task automatic t_reset();
      @(negedge clk);
      check("R1", "empty", 128'(buf_empty), 128'(1));
      check("R1", "full", 128'(buf_full), 128'(0));
      check("R1", "dr_valid", 128'(dr_valid), 128'(0));
      check("R1", "st_ready", 128'(st_ready), 128'(1));
   endtask

   // R2 R3 R4 R5 R6 R7
   task automatic t_merge_order();
      bit acc;
      int base = ncap;
      dr_ready = 1'b0;
      push(32'h0000_0105, 64'hA7A6A5A4_A3A2A1A0, 8'hFF, acc);
      check("R2", "accept A lo", 128'(acc), 128'(1));
      push(32'h0000_0200, 64'hB7B6B5B4_B3B2B1B0, 8'hFF, acc);
      push(32'h0000_0208, 64'hC7C6C5C4_C3C2C1C0, 8'hFF, acc);
      push(32'h0000_0108, 64'hD7D6D5D4_D3D2D1D0, 8'hFF, acc);
      check("R4", "accept A hi", 128'(acc), 128'(1));
      idle();
      check("R6", "head offered", 128'(dr_valid), 128'(1));
      check("R6", "head addr", 128'(dr_addr), 128'(32'h0000_0100));
      check("R9", "not full at 3", 128'(buf_full), 128'(0));
      dr_ready = 1'b1;
      wait_caps(base + 3);
      check("R5", "count of writes", 128'(ncap - base), 128'(3));
      check("R2", "w0 addr", 128'(c_addr[base]), 128'(32'h0000_0100));
      check("R2", "w0 mask", 128'(c_mask[base]), 128'(16'h00FF));
      check("R2", "w0 data", c_data[base], {64'h0, 64'hA7A6A5A4_A3A2A1A0});
      check("R3", "w1 addr", 128'(c_addr[base+1]), 128'(32'h0000_0200));
      check("R3", "w1 mask", 128'(c_mask[base+1]), 128'(16'hFFFF));
      check("R3", "w1 data", c_data[base+1], {64'hC7C6C5C4_C3C2C1C0, 64'hB7B6B5B4_B3B2B1B0});
      check("R4", "w2 addr", 128'(c_addr[base+2]), 128'(32'h0000_0100));
      check("R4", "w2 mask", 128'(c_mask[base+2]), 128'(16'hFF00));
      check("R4", "w2 data", c_data[base+2], {64'hD7D6D5D4_D3D2D1D0, 64'h0});
      check("R7", "w0->w1 spacing", 128'(c_cyc[base+1] - c_cyc[base]), 128'(DC));
      check("R7", "w1->w2 spacing", 128'(c_cyc[base+2] - c_cyc[base+1]), 128'(DC));
      settle();
      check("R9", "empty after drain", 128'(buf_empty), 128'(1));
   endtask

   // R8 R9 R4 R5
   task automatic t_full();
      bit acc;
      int base = ncap;
      dr_ready = 1'b0;
      push(32'h0000_0500, 64'h1111_1111_1111_1111, 8'hFF, acc);
      push(32'h0000_0610, 64'h2222_2222_2222_2222, 8'hFF, acc);
      push(32'h0000_0720, 64'h3333_3333_3333_3333, 8'hFF, acc);
      push(32'h0000_0830, 64'h4444_4444_4444_4444, 8'hFF, acc);
      check("R8", "fourth store taken", 128'(acc), 128'(1));
      idle();
      check("R9", "full at 4", 128'(buf_full), 128'(1));
      check("R9", "not empty at 4", 128'(buf_empty), 128'(0));
      push(32'h0000_0940, 64'h5555_5555_5555_5555, 8'hFF, acc);
      check("R8", "new block stalled", 128'(acc), 128'(0));
      push(32'h0000_0940, 64'h5555_5555_5555_5555, 8'hFF, acc);
      check("R8", "still stalled", 128'(acc), 128'(0));
      push(32'h0000_0508, 64'h6666_6666_6666_6666, 8'hFF, acc);
      check("R4", "offered head refuses merge", 128'(acc), 128'(0));
      push(32'h0000_0728, 64'h7777_7777_7777_7777, 8'hFF, acc);
      check("R8", "merge while full", 128'(acc), 128'(1));
      idle();
      check("R9", "still full after merge", 128'(buf_full), 128'(1));
      dr_ready = 1'b1;
      wait_caps(base + 4);
      settle();
      check("R8", "no stalled store written", 128'(ncap - base), 128'(4));
      check("R5", "order 0", 128'(c_addr[base]), 128'(32'h0000_0500));
      check("R5", "order 1", 128'(c_addr[base+1]), 128'(32'h0000_0610));
      check("R5", "order 2", 128'(c_addr[base+2]), 128'(32'h0000_0720));
      check("R5", "order 3", 128'(c_addr[base+3]), 128'(32'h0000_0830));
      check("R8", "merged mask", 128'(c_mask[base+2]), 128'(16'hFFFF));
      check("R8", "merged data", c_data[base+2], {64'h7777_7777_7777_7777, 64'h3333_3333_3333_3333});
      check("R9", "empty at end", 128'(buf_empty), 128'(1));
   endtask

   // R6 R7 R3: merging in the occupancy window, partial enables
   task automatic t_window();
      bit acc;
      int base  = ncap;
      int abase = nacc;
      dr_ready = 1'b1;
      push(32'h0000_0300, 64'h0807060504030201, 8'hFF, acc);
      push(32'h0000_0400, 64'h1716151413121110, 8'hFF, acc);
      push(32'h0000_0408, 64'h2F2E2D2C2B2A2928, 8'h0F, acc);
      push(32'h0000_0400, 64'h3F3E3D3C3B3A3938, 8'hF0, acc);
      idle();
      wait_caps(base + 2);
      check("R6", "first write one cycle after store", 128'(c_cyc[base] - a_cyc[abase]), 128'(1));
      check("R7", "window spacing", 128'(c_cyc[base+1] - c_cyc[base]), 128'(DC));
      check("R3", "window addr", 128'(c_addr[base+1]), 128'(32'h0000_0400));
      check("R3", "window mask", 128'(c_mask[base+1]), 128'(16'h0FFF));
      check("R3", "window data", c_data[base+1], {64'h00000000_2B2A2928, 64'h3F3E3D3C_13121110});
      settle();
      check("R9", "empty after window", 128'(buf_empty), 128'(1));
   endtask

   // R7: back-to-back release after backpressure
   task automatic t_spacing();
      bit acc;
      int base = ncap;
      dr_ready = 1'b0;
      push(32'h0000_0A00, 64'h1, 8'h01, acc);
      push(32'h0000_0B00, 64'h2, 8'h01, acc);
      idle();
      @(negedge clk);
      dr_ready = 1'b1;
      wait_caps(base + 2);
      check("R7", "release spacing", 128'(c_cyc[base+1] - c_cyc[base]), 128'(DC));
      check("R2", "single byte mask", 128'(c_mask[base+1]), 128'(16'h0001));
      settle();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog all actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      rst_n    = 1'b0;
      st_valid = 1'b0;
      st_addr  = '0;
      st_data  = '0;
      st_be    = '0;
      dr_ready = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_merge_order();
      t_full();
      t_window();
      t_spacing();
      summary();
      $finish;
   end

endmodule